// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block is the master side of an external bus that has separate address and data lines. It takes one access at a time from an internal requester. The access can be a read or a write, to memory space or to I/O space. The block runs it on the external pins as four timed phases: T1, T2, T3 and T4. A peripheral that needs more time can stretch the access by holding its ready line low, which adds whole wait phases between T3 and T4.

Every phase lasts N system clocks. N comes from a configuration input and is latched when the request is accepted. An address-latch strobe pulses during the first half of T1. The read or write strobe and the space strobe (memory or I/O) become active in T2. For reads, the input data is captured on the clock edge that starts T4. One clock after T4 ends, the requester gets a single-clock done pulse, together with the read data. While an access is in progress the block is busy, and it ignores new requests.

Top module: `xbus_cycle_ctl`

## Requirements
- R1: After reset, and whenever the block is idle: busy is 0, bus_ale and bus_doe are 0, and bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n and bus_iorq_n are all 1.
- R2: N is latched from cfg_phase_len in the clock in which the request is accepted. A value of 0 or 1 is treated as 2. Later changes to cfg_phase_len do not affect the access in progress. T1, T2, T3, T4 and each wait phase last exactly N clocks, and busy is 1 for the whole access.
- R3: From the first clock of T1 to the last clock of T4, bus_cs_n is 0 and bus_addr carries the request address. For a write (req_write=1), bus_doe is 1 and bus_dout carries the write data over the same span. For a read, bus_doe stays 0.
- R4: bus_ale is 1 for the first floor(N/2) clocks of T1 and 0 at every other time.
- R5: For a read, bus_rd_n is 0 from the start of T2 through the end of T3 and any wait phases, and 1 in T4. For a write, bus_wr_n follows the same window. The two strobes are never 0 together.
- R6: From the start of T2 through the end of T4, bus_mreq_n is 0 for a memory access (req_io=0) and bus_iorq_n is 0 for an I/O access (req_io=1). The other strobe stays 1.
- R7: No bus output changes between consecutive clocks of T3.
- R8: bus_ready is sampled in the last clock of T2. If it is 0 there, one wait phase follows T3. In the last clock of each wait phase bus_ready is sampled again, and another wait phase follows while it is 0.
- R9: For a read, rsp_rdata takes the value bus_din had in the last clock before T4. rsp_done is 1 for exactly one clock, the clock after T4 ends.
- R10: A request (req_valid=1) is accepted only while busy is 0, and that includes the clock that carries rsp_done. A request presented while busy is ignored: the bus address does not change and no extra access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phase_len | input | LW | Phase length N in clocks (values below 2 mean 2) |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Captured read data |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | External data bus, outgoing value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DW | External data bus, incoming value |
| bus_ready | input | 1 | Peripheral ready, low inserts waits |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mreq_n | output | 1 | Memory space strobe, active low |
| bus_iorq_n | output | 1 | I/O space strobe, active low |

## Verification
All strobes are decoded from the phase and the in-phase clock count. A wrong count or a wrong phase transition therefore moves an edge of cs, ale, rd, wr or the space strobe, and the per-clock comparison catches that edge in the very clock it happens. A wrong wait decision shifts the edge that ends the strobe by a whole phase, N clocks, at the end of T3. A wrongly captured read value or a lost done pulse shows up in the clock after T4.

// File: rtl/xbus_cycle_ctl.sv
module xbus_cycle_ctl #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_phase_len,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_mreq_n,
  output logic          bus_iorq_n
);

  localparam logic [LW-1:0] MIN_LEN = LW'(2);

  typedef enum logic [2:0] {P_IDLE, P_T1, P_T2, P_T3, P_TW, P_T4} phase_t;

  phase_t        phase;
  logic [LW-1:0] cnt, len;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q, io_q, wait_q;

  wire [LW-1:0] eff_len = (cfg_phase_len < MIN_LEN) ? MIN_LEN : cfg_phase_len;
  wire          last    = (cnt == len - LW'(1));
  wire          active  = (phase != P_IDLE);
  wire          strobe  = (phase == P_T2) || (phase == P_T3) || (phase == P_TW);
  wire          space   = strobe || (phase == P_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cnt       <= '0;
      len       <= MIN_LEN;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      io_q      <= 1'b0;
      wait_q    <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (phase == P_IDLE) begin
        if (req_valid) begin
          phase   <= P_T1;
          cnt     <= '0;
          len     <= eff_len;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          io_q    <= req_io;
        end
      end else if (!last) begin
        cnt <= cnt + LW'(1);
      end else begin
        cnt <= '0;
        case (phase)
          P_T1: phase <= P_T2;
          P_T2: begin
            phase  <= P_T3;
            wait_q <= !bus_ready;
          end
          P_T3: begin
            if (wait_q) phase <= P_TW;
            else begin
              phase <= P_T4;
              if (!wr_q) rsp_rdata <= bus_din;
            end
          end
          P_TW: begin
            if (bus_ready) begin
              phase <= P_T4;
              if (!wr_q) rsp_rdata <= bus_din;
            end
          end
          P_T4: begin
            phase    <= P_IDLE;
            rsp_done <= 1'b1;
          end
          default: phase <= P_IDLE;
        endcase
      end
    end
  end

  assign busy       = active;
  assign bus_addr   = addr_q;
  assign bus_dout   = wdata_q;
  assign bus_doe    = active && wr_q;
  assign bus_cs_n   = !active;
  assign bus_ale    = (phase == P_T1) && (cnt < (len >> 1));
  assign bus_rd_n   = !(strobe && !wr_q);
  assign bus_wr_n   = !(strobe && wr_q);
  assign bus_mreq_n = !(space && !io_q);
  assign bus_iorq_n = !(space && io_q);

  // R4
  ale_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !bus_cs_n);

  // R3
  doe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_cs_n);

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R6
  space_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_mreq_n && !bus_iorq_n));

  // R7
  t3_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_T3 && $past(phase) == P_T3) |->
      $stable({bus_addr, bus_dout, bus_doe, bus_ale, bus_cs_n,
               bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n}));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(bus_addr));

endmodule

// File: tb/xbus_cycle_ctl_test.sv
module xbus_cycle_ctl_test;
  localparam int AW = 24, DW = 8, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] cfg_phase_len = 4'd2;
  logic req_valid = 0, req_write = 0, req_io = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic bus_ready = 1'b1;
  logic busy, rsp_done, bus_doe, bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  int tests = 0, fails = 0;
  int lo_s = 0, lo_e = 0;

  always #5 clk = ~clk;

  xbus_cycle_ctl #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_phase_len(cfg_phase_len),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_ready(bus_ready), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_mreq_n(bus_mreq_n),
    .bus_iorq_n(bus_iorq_n));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  function automatic bit rdy_at(int k);
    return !(k >= lo_s && k < lo_e);
  endfunction

  task automatic chk_idle(string tag);
    chk("R1", {tag, " busy"}, busy, 0);
    chk("R1", {tag, " ale"}, bus_ale, 0);
    chk("R1", {tag, " doe"}, bus_doe, 0);
    chk("R1", {tag, " strobes"}, {bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n}, 5'b11111);
  endtask

  // one access; cfg is the input value, n the length the requirements imply
  task automatic run(input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit wr,
                     input bit io, input int cfg, input int n, input int ls, input int le,
                     input logic [DW-1:0] din, input bit poke_busy, input bit change_cfg);
    int w, t4s, fin;
    lo_s = ls; lo_e = le;
    w = 0;
    if (!rdy_at(2*n-1)) begin
      w = 1;
      while (!rdy_at(3*n + w*n - 1)) w++;
    end
    t4s = 3*n + w*n;
    fin = t4s + n;
    cfg_phase_len = LW'(cfg);
    req_valid = 1; req_addr = a; req_wdata = wd; req_write = wr; req_io = io;
    bus_din = din;
    @(negedge clk);
    req_valid = 0;
    if (change_cfg) cfg_phase_len = 4'd9;
    for (int k = 0; k <= fin; k++) begin
      bus_ready = rdy_at(k);
      if (poke_busy && k >= 1 && k <= 3) begin
        req_valid = 1; req_addr = 24'hABCDEF;
      end else req_valid = 0;
      if (k < fin) begin
        chk("R2", "busy", busy, 1);
        chk("R3", "cs_n", bus_cs_n, 0);
        chk("R3", "addr", bus_addr, a);
        chk("R3", "doe", bus_doe, wr);
        if (wr) chk("R3", "dout", bus_dout, wd);
        chk("R4", "ale", bus_ale, (k < n/2));
        chk("R5", "rd_n", bus_rd_n, !(!wr && k >= n && k < t4s));
        chk("R8 R5", "wr_n", bus_wr_n, !(wr && k >= n && k < t4s));
        chk("R6", "mreq_n", bus_mreq_n, !(!io && k >= n));
        chk("R6", "iorq_n", bus_iorq_n, !(io && k >= n));
        chk("R9", "done early", rsp_done, 0);
      end else begin
        chk("R9", "done", rsp_done, 1);
        if (!wr) chk("R9", "rdata", rsp_rdata, din);
        chk_idle("R1");
      end
      @(negedge clk);
    end
    bus_ready = 1;
    req_valid = 0;
    chk("R9", "done width", rsp_done, 0);
    chk("R10", "no extra access", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1 after reset");
    // R3 R5 R6: memory read, N=2, no waits
    run(24'h123456, 8'h00, 0, 0, 2, 2, -1, -1, 8'h5A, 0, 0);
    // R3 R6: I/O write, N=3
    run(24'h000042, 8'hC3, 1, 1, 3, 3, -1, -1, 8'h00, 0, 0);
    // R8: ready low in last T2 clock, one wait, N=4
    run(24'h0F0F0F, 8'h00, 0, 1, 4, 4, 7, 8, 8'h99, 0, 0);
    // R8: ready low across two wait checkpoints, write, N=2
    run(24'h777777, 8'h3C, 1, 0, 2, 2, 0, 8, 8'h00, 0, 0);
    // R8: ready low only during T3 (not sampled), no waits
    run(24'h111111, 8'h00, 0, 0, 3, 3, 6, 9, 8'hE7, 0, 0);
    // R2: cfg 0 and 1 behave as 2, cfg 15 max, cfg change mid-access ignored
    run(24'h200000, 8'h00, 0, 0, 0, 2, -1, -1, 8'h11, 0, 1);
    run(24'h300000, 8'hA5, 1, 1, 1, 2, -1, -1, 8'h00, 0, 0);
    run(24'h400000, 8'h00, 0, 0, 15, 15, 29, 30, 8'h42, 0, 1);
    // R10: requests during busy ignored
    run(24'h555555, 8'h00, 0, 0, 5, 5, -1, -1, 8'h24, 1, 0);
    // R10: back-to-back accept in the done clock
    req_valid = 1; req_addr = 24'h666666; req_write = 0; req_io = 0; cfg_phase_len = 4'd2;
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    chk("R10", "done before back-to-back", rsp_done, 1);
    req_valid = 1; req_addr = 24'h999999;
    @(negedge clk);
    req_valid = 0;
    chk("R10", "accepted in done clock", busy, 1);
    chk("R10", "new address", bus_addr, 24'h999999);
    repeat (9) @(negedge clk);
    chk_idle("R1 end");
    summary();
    $finish;
  end
endmodule